// File: doc/BRIEF.md
# Latched Processor Event Counter

This block watches a processor core and keeps four free-running counters of its activity: elapsed clock cycles, executed opcodes, interrupt-request handler entries and non-maskable-interrupt handler entries. It also receives a wall-clock time from an external source in two encodings, a single nanosecond total and a seconds/nanoseconds pair, together with a flag saying whether that time is trustworthy.

Software reaches the block through a byte-wide bus with ten byte offsets. Writing the capture offset freezes every counter and both time encodings into a bank of snapshot registers in one clock edge. Software then writes a code into the selector register and reads the chosen snapshot one byte at a time through an eight-byte window. The snapshot does not move while the live counters keep running, so a 64-bit value read over an 8-bit bus never tears.

The core reports each completed step as a one-cycle pulse with a kind (opcode, IRQ entry, NMI entry or other) and the number of clock cycles the step consumed.

Top module: `cpu_evt_snapshot`

## Requirements
- R1: After reset every live counter, every snapshot and the selector register read as zero.
- R2: Writing offset 1 stores the 8-bit data in the selector; reading offset 1 returns it. No other bus write changes it.
- R3: A write of any data to offset 0 copies all live counters and both time inputs into the snapshots; snapshots keep that value until the next such write, whatever the live counters or time inputs do.
- R4: Offsets 2 to 9 form the window: offset 2 returns bits 7:0 of the selected snapshot, offset 2+k returns bits 8k+7:8k, offset 9 returns bits 63:56.
- R5: Every step pulse adds its cycle count (0 to 15) to the cycle counter, whatever its kind.
- R6: Kind 0 (opcode) adds one to the instruction counter only; kind 1 (IRQ entry) adds one to the IRQ counter only; kind 2 (NMI entry) adds one to the NMI counter only; kind 3 touches no event counter.
- R7: Selector codes 0x00, 0x01, 0x02, 0x03 show the cycle, instruction, IRQ and NMI snapshots; 0x80 shows the nanosecond-total time; 0x81 shows the split time, seconds in bits 63:32 and nanoseconds in bits 31:0.
- R8: A capture while the time-valid input is low sets both time snapshots to all ones.
- R9: Any other selector code makes all eight window bytes read zero.
- R10: Bus writes to offsets 2 to 15 change nothing; reads of offset 0 and of offsets 10 to 15 return zero.
- R11: A step pulse in the same cycle as a capture write is counted, but the snapshot holds the value from before that step.
- R12: While the read strobe is low the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte offset within the block |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational from address and strobe |
| step_valid | input | 1 | One pulse per completed core step |
| step_kind | input | 2 | 0 opcode, 1 IRQ entry, 2 NMI entry, 3 other |
| step_cycles | input | 4 | Clock cycles consumed by the step |
| time_valid | input | 1 | High when the time inputs are trustworthy |
| time_ns | input | 64 | Time as total nanoseconds |
| time_split | input | 64 | Time as seconds (63:32) and nanoseconds (31:0) |

## Verification
A table of step bursts drives the counters with runs of every kind, including zero-cycle opcodes, maximum-cost opcodes and kind 3 steps, and after each burst the four counter snapshots are compared to a running model; this separates a cycle counter that adds the step cost from one that adds one per step, and an event counter that listens to the wrong kind. Time patterns with distinct bytes in every lane, read byte by byte, expose byte-order and selector-decode faults, while an invalid-time capture and unknown selector codes separate the all-ones and all-zero cases. A step landing on the same edge as a capture tells a pre-step snapshot from a post-step one.

// File: rtl/evs_pkg.sv
package evs_pkg;

    typedef enum logic [1:0] {
        STEP_OPCODE = 2'd0,
        STEP_IRQ    = 2'd1,
        STEP_NMI    = 2'd2,
        STEP_OTHER  = 2'd3
    } step_kind_e;

    typedef enum logic [7:0] {
        SEL_CYCLES = 8'h00,
        SEL_INSTR  = 8'h01,
        SEL_IRQ    = 8'h02,
        SEL_NMI    = 8'h03,
        SEL_TNS    = 8'h80,
        SEL_TSPLIT = 8'h81
    } sel_code_e;

    // Byte offsets decoded by the bus front end
    localparam int unsigned OFS_CAPTURE = 0;
    localparam int unsigned OFS_SELECT  = 1;
    localparam int unsigned OFS_WINDOW  = 2;

    // Snapshot bank slots
    localparam int unsigned SLOT_CYC    = 0;
    localparam int unsigned SLOT_EV0    = 1;
    localparam int unsigned SLOT_TNS    = 4;
    localparam int unsigned SLOT_TSPLIT = 5;
    localparam int unsigned N_EVENTS    = 3;
    localparam int unsigned N_SLOTS     = 6;

endpackage

// File: rtl/evs_live_ctr.sv
module evs_live_ctr
    import evs_pkg::*;
#(
    parameter int unsigned CNT_W = 64,
    parameter int unsigned CYC_W = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               step_valid,
    input  logic [1:0]                         step_kind,
    input  logic [CYC_W-1:0]                   step_cycles,
    output logic [CNT_W-1:0]                   live_cyc,
    output logic [N_EVENTS-1:0][CNT_W-1:0]     live_ev
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_cyc <= '0;
        end else if (step_valid) begin
            live_cyc <= live_cyc + CNT_W'(step_cycles);
        end
    end

    // One event counter per step kind 0..N_EVENTS-1
    for (genvar g = 0; g < N_EVENTS; g++) begin : g_ev
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_ev[g] <= '0;
            end else if (step_valid && (step_kind == 2'(g))) begin
                live_ev[g] <= live_ev[g] + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/evs_snap_bank.sv
module evs_snap_bank
    import evs_pkg::*;
#(
    parameter int unsigned CNT_W = 64
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               capture,
    input  logic [CNT_W-1:0]                   live_cyc,
    input  logic [N_EVENTS-1:0][CNT_W-1:0]     live_ev,
    input  logic                               time_valid,
    input  logic [CNT_W-1:0]                   time_ns,
    input  logic [CNT_W-1:0]                   time_split,
    output logic [N_SLOTS-1:0][CNT_W-1:0]      snap
);

    logic [N_SLOTS-1:0][CNT_W-1:0] src;

    always_comb begin
        src[SLOT_CYC] = live_cyc;
        for (int i = 0; i < N_EVENTS; i++) begin
            src[SLOT_EV0 + i] = live_ev[i];
        end
        src[SLOT_TNS]    = time_valid ? time_ns    : '1;
        src[SLOT_TSPLIT] = time_valid ? time_split : '1;
    end

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                snap[s] <= '0;
            end else if (capture) begin
                snap[s] <= src[s];
            end
        end
    end

endmodule

// File: rtl/evs_read_mux.sv
module evs_read_mux
    import evs_pkg::*;
#(
    parameter int unsigned CNT_W  = 64,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                               bus_rd,
    input  logic [ADDR_W-1:0]                  bus_addr,
    input  logic [7:0]                         sel_q,
    input  logic [N_SLOTS-1:0][CNT_W-1:0]      snap,
    output logic [7:0]                         bus_rdata
);

    localparam int unsigned NBYTES = CNT_W / 8;
    localparam int unsigned IDX_W  = $clog2(NBYTES);

    logic [CNT_W-1:0]  word;
    logic [ADDR_W-1:0] rel;
    logic [IDX_W-1:0]  idx;
    logic              in_win;
    logic [CNT_W-1:0]  shifted;

    always_comb begin
        unique case (sel_q)
            SEL_CYCLES: word = snap[SLOT_CYC];
            SEL_INSTR:  word = snap[SLOT_EV0];
            SEL_IRQ:    word = snap[SLOT_EV0 + 1];
            SEL_NMI:    word = snap[SLOT_EV0 + 2];
            SEL_TNS:    word = snap[SLOT_TNS];
            SEL_TSPLIT: word = snap[SLOT_TSPLIT];
            default:    word = '0;
        endcase
    end

    always_comb begin
        rel     = bus_addr - ADDR_W'(OFS_WINDOW);
        idx     = rel[IDX_W-1:0];
        in_win  = (bus_addr >= ADDR_W'(OFS_WINDOW)) &&
                  (bus_addr <  ADDR_W'(OFS_WINDOW + NBYTES));
        shifted = word >> {idx, 3'b000};
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == ADDR_W'(OFS_SELECT)) begin
                bus_rdata = sel_q;
            end else if (in_win) begin
                bus_rdata = shifted[7:0];
            end
        end
    end

endmodule

// File: rtl/cpu_evt_snapshot.sv
module cpu_evt_snapshot
    import evs_pkg::*;
#(
    parameter int unsigned CNT_W  = 64,
    parameter int unsigned CYC_W  = 4,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic              step_valid,
    input  logic [1:0]        step_kind,
    input  logic [CYC_W-1:0]  step_cycles,
    input  logic              time_valid,
    input  logic [CNT_W-1:0]  time_ns,
    input  logic [CNT_W-1:0]  time_split
);

    logic                           capture;
    logic                           sel_wr;
    logic [7:0]                     sel_q;
    logic [CNT_W-1:0]               live_cyc;
    logic [N_EVENTS-1:0][CNT_W-1:0] live_ev;
    logic [N_SLOTS-1:0][CNT_W-1:0]  snap_all;

    assign capture = bus_wr && (bus_addr == ADDR_W'(OFS_CAPTURE));
    assign sel_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_SELECT));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (sel_wr) begin
            sel_q <= bus_wdata;
        end
    end

    evs_live_ctr #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_live (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_valid  (step_valid),
        .step_kind   (step_kind),
        .step_cycles (step_cycles),
        .live_cyc    (live_cyc),
        .live_ev     (live_ev)
    );

    evs_snap_bank #(.CNT_W(CNT_W)) u_snap (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .live_cyc   (live_cyc),
        .live_ev    (live_ev),
        .time_valid (time_valid),
        .time_ns    (time_ns),
        .time_split (time_split),
        .snap       (snap_all)
    );

    evs_read_mux #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .sel_q     (sel_q),
        .snap      (snap_all),
        .bus_rdata (bus_rdata)
    );

endmodule

// File: rtl/cpu_evt_snapshot_chk.sv
module cpu_evt_snapshot_chk
    import evs_pkg::*;
#(
    parameter int unsigned CNT_W  = 64,
    parameter int unsigned ADDR_W = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic                           bus_wr,
    input logic                           bus_rd,
    input logic [7:0]                     bus_rdata,
    input logic                           step_valid,
    input logic [1:0]                     step_kind,
    input logic                           time_valid,
    input logic [7:0]                     sel_q,
    input logic [CNT_W-1:0]               live_cyc,
    input logic [N_EVENTS-1:0][CNT_W-1:0] live_ev,
    input logic [N_SLOTS-1:0][CNT_W-1:0]  snap_all
);

    logic wr_cap;
    logic wr_sel;
    assign wr_cap = bus_wr && (bus_addr == ADDR_W'(0));
    assign wr_sel = bus_wr && (bus_addr == ADDR_W'(1));

    a_r3_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cap |=> $stable(snap_all));

    a_r11_pre_step_value: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cap |=> snap_all[SLOT_CYC] == $past(live_cyc));

    a_r8_bad_time_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cap && !time_valid) |=> (snap_all[SLOT_TNS] == '1) && (snap_all[SLOT_TSPLIT] == '1));

    a_r6_irq_not_instr: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && step_kind == 2'd1) |=> $stable(live_ev[0]));

    a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(sel_q));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == 8'h00);

    a_r10_capture_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(0)) |-> bus_rdata == 8'h00);

endmodule

bind cpu_evt_snapshot cpu_evt_snapshot_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .step_valid (step_valid),
    .step_kind  (step_kind),
    .time_valid (time_valid),
    .sel_q      (sel_q),
    .live_cyc   (live_cyc),
    .live_ev    (live_ev),
    .snap_all   (snap_all)
);

// File: tb/test_cpu_evt_snapshot.sv
module test_cpu_evt_snapshot;

    localparam int CLK_PERIOD = 10;
    localparam int N_STIM     = 8;

    // {kind[13:12], cycles[11:8], repeat[7:0]}
    localparam logic [15:0] STIM [N_STIM] = '{
        {2'b00, 2'd0, 4'd2,  8'd3},
        {2'b00, 2'd1, 4'd7,  8'd1},
        {2'b00, 2'd0, 4'd15, 8'd4},
        {2'b00, 2'd2, 4'd7,  8'd2},
        {2'b00, 2'd0, 4'd0,  8'd5},
        {2'b00, 2'd1, 4'd6,  8'd3},
        {2'b00, 2'd3, 4'd9,  8'd2},
        {2'b00, 2'd0, 4'd1,  8'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        step_valid = 1'b0;
    logic [1:0]  step_kind = '0;
    logic [3:0]  step_cycles = '0;
    logic        time_valid = 1'b1;
    logic [63:0] time_ns = '0;
    logic [63:0] time_split = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [63:0] m_cyc = '0, m_ins = '0, m_irq = '0, m_nmi = '0;

    cpu_evt_snapshot i_cpu_evt_snapshot (
        .clk, .rst_n, .bus_addr, .bus_wdata, .bus_wr, .bus_rd, .bus_rdata,
        .step_valid, .step_kind, .step_cycles, .time_valid, .time_ns, .time_split
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic read64(input logic [7:0] sel, output logic [63:0] v);
        logic [7:0] b;
        bus_write(4'd1, sel);
        for (int i = 0; i < 8; i++) begin
            bus_read(4'(2 + i), b);
            v[i*8 +: 8] = b;
        end
    endtask

    task automatic run_steps(input logic [1:0] k, input logic [3:0] c, input int n);
        if (n > 0) begin
            @(negedge clk);
            step_valid = 1'b1; step_kind = k; step_cycles = c;
            repeat (n) @(negedge clk);
            step_valid = 1'b0;
            m_cyc += 64'(c) * 64'(n);
            case (k)
                2'd0: m_ins += 64'(n);
                2'd1: m_irq += 64'(n);
                2'd2: m_nmi += 64'(n);
                default: ;
            endcase
        end
    endtask

    task automatic check_counters(input string tag);
        logic [63:0] v;
        read64(8'h00, v); check({tag, " R5 cycles"}, v, m_cyc);
        read64(8'h01, v); check({tag, " R6 instr"},  v, m_ins);
        read64(8'h02, v); check({tag, " R6 irq"},    v, m_irq);
        read64(8'h03, v); check({tag, " R6 nmi"},    v, m_nmi);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [63:0] v;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(4'd1, b); check("R1 select after reset", 64'(b), 64'h0);
        read64(8'h00, v); check("R1 cycles snap", v, 64'h0);
        read64(8'h03, v); check("R1 nmi snap", v, 64'h0);
        read64(8'h81, v); check("R1 split snap", v, 64'h0);

        // R5 R6 table walk
        for (int e = 0; e < N_STIM; e++) begin
            run_steps(STIM[e][13:12], STIM[e][11:8], int'(STIM[e][7:0]));
            bus_write(4'd0, 8'h5A);
            check_counters($sformatf("R3 entry%0d", e));
        end

        // R3: snapshot holds while live counters run
        run_steps(2'd0, 4'd3, 4);
        read64(8'h00, v); check("R3 held while running", v, m_cyc - 64'd12);

        // R11: step on capture edge
        bus_write(4'd0, 8'h00);
        @(negedge clk);
        step_valid = 1'b1; step_kind = 2'd0; step_cycles = 4'd5;
        bus_addr = 4'd0; bus_wr = 1'b1;
        @(negedge clk);
        step_valid = 1'b0; bus_wr = 1'b0;
        read64(8'h00, v); check("R11 pre-step cycles", v, m_cyc);
        read64(8'h01, v); check("R11 pre-step instr", v, m_ins);
        m_cyc += 64'd5; m_ins += 64'd1;
        bus_write(4'd0, 8'hFF);
        check_counters("R11 after recapture");

        // R7 R4: time formats and byte order
        time_valid = 1'b1;
        time_ns    = 64'h0123_4567_89AB_CDEF;
        time_split = {32'h6553_F100, 32'd999_999_999};
        bus_write(4'd0, 8'h11);
        read64(8'h80, v); check("R7 time ns", v, 64'h0123_4567_89AB_CDEF);
        read64(8'h81, v); check("R7 time split", v, {32'h6553_F100, 32'd999_999_999});
        bus_write(4'd1, 8'h80);
        bus_read(4'd2, b); check("R4 offset2 lsb", 64'(b), 64'hEF);
        bus_read(4'd5, b); check("R4 offset5", 64'(b), 64'h89);
        bus_read(4'd9, b); check("R4 offset9 msb", 64'(b), 64'h01);

        // R3: time input changes without capture are not seen
        time_ns = 64'hDEAD_BEEF_0000_0001;
        read64(8'h80, v); check("R3 time held", v, 64'h0123_4567_89AB_CDEF);

        // R10: writes to window and unused offsets ignored; reads zero
        bus_write(4'd5, 8'hFF);
        bus_write(4'd12, 8'h03);
        bus_read(4'd1, b); check("R10 select untouched", 64'(b), 64'h80);
        read64(8'h80, v); check("R10 window write ignored", v, 64'h0123_4567_89AB_CDEF);
        bus_read(4'd0, b); check("R10 offset0 reads zero", 64'(b), 64'h0);
        bus_read(4'd12, b); check("R10 offset12 reads zero", 64'(b), 64'h0);

        // R12: no read strobe
        @(negedge clk);
        bus_addr = 4'd2; bus_rd = 1'b0;
        #1;
        check("R12 idle read data", 64'(bus_rdata), 64'h0);

        // R8: invalid time
        time_valid = 1'b0;
        bus_write(4'd0, 8'h00);
        time_valid = 1'b1;
        read64(8'h80, v); check("R8 ns all ones", v, 64'hFFFF_FFFF_FFFF_FFFF);
        read64(8'h81, v); check("R8 split all ones", v, 64'hFFFF_FFFF_FFFF_FFFF);

        // R2 R9: unknown codes, readback
        bus_write(4'd1, 8'hA5);
        bus_read(4'd1, b); check("R2 select readback", 64'(b), 64'hA5);
        read64(8'h04, v); check("R9 code 0x04 zero", v, 64'h0);
        read64(8'h7F, v); check("R9 code 0x7F zero", v, 64'h0);
        read64(8'hFF, v); check("R9 code 0xFF zero", v, 64'h0);
        read64(8'h82, v); check("R9 code 0x82 zero", v, 64'h0);

        // R1: reset clears live state
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_cyc = '0; m_ins = '0; m_irq = '0; m_nmi = '0;
        bus_read(4'd1, b); check("R1 select cleared", 64'(b), 64'h0);
        bus_write(4'd0, 8'h00);
        check_counters("R1 after second reset");

        finish_run();
    end

endmodule